// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block drives a chain of external serial-in LED devices from three pins: a serial clock, a serial data line and a latch strobe. It refreshes a 12-bit vector of LED states without pause, one 36-cycle frame after another. The serial clock is made from the system clock by dividing a clock-enable tick by an even ratio. The data line only moves when the serial clock falls, so the external devices can take it on the rising edge.

One mode input picks the frame format. Format 0 suits a latchless driver. It sends a leading start bit, two zero fillers and then the twelve LED bits, and zeros fill out the frame. Format 1 suits shift registers with output latches. It sends the twelve LED bits first and zeros after them. During the low half of cycle 35 it raises the latch strobe once, which moves the shifted pattern to the device outputs. The LED vector and the mode are both taken at the start of cycle 1, so every frame is built from one consistent snapshot.

Top module: `led_serial_out`

## Requirements
- R1: A frame is exactly 36 serial clock cycles, and frames follow each other with no gap. In format 1 the strobe therefore repeats every 36 × CLK_DIV ticks.
- R2: The data line changes only when the serial clock goes from high to low.
- R3: The serial clock is high for CLK_DIV/2 ticks and low for CLK_DIV/2 ticks.
- R4: In format 0 (mode_sel = 0), cycle 1 carries a 1, cycles 2 and 3 carry 0, cycles 4 to 15 carry led_vec[0] to led_vec[11] in that order, and cycles 16 to 36 carry 0.
- R5: In format 1 (mode_sel = 1), cycles 1 to 12 carry led_vec[0] to led_vec[11] in that order, and cycles 13 to 36 carry 0.
- R6: LED bits use true polarity, so a 1 drives the line high. Every position without an LED bit or the start bit is 0, even when all LED bits are 1.
- R7: In format 1, ser_latch rises once per frame, in the low half of cycle 35. It falls again before the serial clock rises, so it is never high while the serial clock is high.
- R8: In format 0, ser_latch stays low for the whole frame.
- R9: led_vec and mode_sel are sampled only at the start of cycle 1. A change in the middle of a frame shows up only in the next frame.
- R10: While reset is active, all three outputs are low. After reset, the first serial clock rise carries a 0 on the data line, and the first fall begins cycle 1.
- R11: The serial clock and the frame stand still on system cycles when tick_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Clock-enable tick that drives the serial clock divider |
| mode_sel | input | 1 | Frame format: 0 for start-bit framing, 1 for latch-strobe framing |
| led_vec | input | 12 | LED states, bit 0 is LED 1 |
| ser_clk | output | 1 | Serial clock to the device chain |
| ser_data | output | 1 | Serial data, changes on the falling serial clock |
| ser_latch | output | 1 | Latch strobe, used in format 1 only |

## Verification
The bench builds the block with its defaults: CLK_DIV = 4, 12 LED bits, a 36-cycle frame, data starting at cycle 4 in format 0 and the strobe at cycle 35. With these values the high phase of the serial clock lasts two ticks. The strobe's one-tick clearing window then falls right after the falling edge, which is the tightest placement the strobe can have. The bench also thins tick_en to one tick in three. This stretches every phase to six system cycles and checks that the strobe and the framing follow the tick rather than the system clock. A frame is only 144 system cycles, so there is time for many whole frames, two resets and a format change in the middle of a frame.

// File: rtl/led_serial_pkg.sv
package led_serial_pkg;

  localparam int unsigned FRAME_CYCLES     = 36;
  localparam int unsigned LED_COUNT        = 12;
  localparam int unsigned START_DATA_FIRST = 4;
  localparam int unsigned STROBE_CYCLE     = 35;
  localparam int unsigned SCLK_RATIO       = 4;

  typedef enum logic {
    FMT_START  = 1'b0,
    FMT_STROBE = 1'b1
  } frame_fmt_e;

endpackage

// File: rtl/lso_reset_sync.sv
module lso_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;

endmodule

// File: rtl/lso_sclk_div.sv
module lso_sclk_div #(
  parameter int unsigned RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic sclk_o,
  output logic fall_en_o,
  output logic prerise_en_o
);

  localparam int unsigned HALF = RATIO / 2;
  localparam int unsigned PW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_PRE  = PW'(HALF - 2);

  logic [PW-1:0] ph_q, ph_nxt;
  logic          sclk_q, sclk_nxt;
  logic          edge_en;

  always_comb begin
    edge_en  = tick_en && (ph_q == PH_LAST);
    ph_nxt   = ph_q;
    sclk_nxt = sclk_q;
    if (tick_en) begin
      if (edge_en) begin
        ph_nxt   = '0;
        sclk_nxt = ~sclk_q;
      end else begin
        ph_nxt = ph_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_nxt;
      sclk_q <= sclk_nxt;
    end
  end

  assign sclk_o       = sclk_q;
  assign fall_en_o    = edge_en && sclk_q;
  assign prerise_en_o = tick_en && !sclk_q && (ph_q == PH_PRE);

  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(sclk_q)); // R11

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= PH_LAST); // R3

endmodule

// File: rtl/lso_frame_seq.sv
module lso_frame_seq
  import led_serial_pkg::*;
#(
  parameter int unsigned FRAME = 36,
  parameter int unsigned LED_W = 12,
  parameter int unsigned CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_en,
  input  frame_fmt_e       fmt_i,
  input  logic [LED_W-1:0] led_i,
  output logic [CW-1:0]    cyc_d_o,
  output frame_fmt_e       fmt_d_o,
  output logic [LED_W-1:0] led_d_o,
  output logic [CW-1:0]    cyc_q_o
);

  localparam logic [CW-1:0] CYC_LAST  = CW'(FRAME);
  localparam logic [CW-1:0] CYC_FIRST = CW'(1);

  logic [CW-1:0]    cyc_q, cyc_nxt;
  frame_fmt_e       fmt_q, fmt_nxt;
  logic [LED_W-1:0] led_q, led_nxt;
  logic             frame_open;

  always_comb begin
    frame_open = fall_en && (cyc_q == CYC_LAST);
    cyc_nxt    = cyc_q;
    fmt_nxt    = fmt_q;
    led_nxt    = led_q;
    if (fall_en) begin
      cyc_nxt = frame_open ? CYC_FIRST : (cyc_q + CW'(1));
    end
    if (frame_open) begin
      fmt_nxt = fmt_i;
      led_nxt = led_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= CYC_LAST;
      fmt_q <= FMT_START;
      led_q <= '0;
    end else begin
      cyc_q <= cyc_nxt;
      fmt_q <= fmt_nxt;
      led_q <= led_nxt;
    end
  end

  assign cyc_d_o = cyc_nxt;
  assign fmt_d_o = fmt_nxt;
  assign led_d_o = led_nxt;
  assign cyc_q_o = cyc_q;

  AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= CYC_FIRST) && (cyc_q <= CYC_LAST)); // R1

  AST_CYC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_en && (cyc_q == CYC_LAST)) |=> (cyc_q == CYC_FIRST)); // R1

  AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != CYC_LAST) |=> ($stable(led_q) && $stable(fmt_q))); // R9

endmodule

// File: rtl/lso_bit_drive.sv
module lso_bit_drive
  import led_serial_pkg::*;
#(
  parameter int unsigned FRAME      = 36,
  parameter int unsigned LED_W      = 12,
  parameter int unsigned DATA_FIRST = 4,
  parameter int unsigned STROBE_CYC = 35,
  parameter int unsigned CW         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_en,
  input  logic             prerise_en,
  input  logic [CW-1:0]    cyc_d,
  input  frame_fmt_e       fmt_d,
  input  logic [LED_W-1:0] led_d,
  input  logic [CW-1:0]    cyc_q,
  output logic             sdata_o,
  output logic             latch_o
);

  logic [FRAME:1] start_vec;
  logic [FRAME:1] strobe_vec;
  logic           bit_sel;
  logic           sdata_q, sdata_nxt;
  logic           latch_q, latch_nxt;

  for (genvar p = 1; p <= FRAME; p++) begin : g_pos
    if (p == 1) begin : g_start
      assign start_vec[p] = 1'b1;
    end else if ((p >= DATA_FIRST) && (p < DATA_FIRST + LED_W)) begin : g_sdat
      assign start_vec[p] = led_d[p - DATA_FIRST];
    end else begin : g_spad
      assign start_vec[p] = 1'b0;
    end

    if (p <= LED_W) begin : g_ldat
      assign strobe_vec[p] = led_d[p - 1];
    end else begin : g_lpad
      assign strobe_vec[p] = 1'b0;
    end
  end

  always_comb begin
    bit_sel   = (fmt_d == FMT_STROBE) ? strobe_vec[cyc_d] : start_vec[cyc_d];
    sdata_nxt = sdata_q;
    latch_nxt = latch_q;
    if (fall_en) begin
      sdata_nxt = bit_sel;
    end
    if (fall_en && (fmt_d == FMT_STROBE) && (cyc_d == CW'(STROBE_CYC))) begin
      latch_nxt = 1'b1;
    end else if (prerise_en) begin
      latch_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sdata_q <= sdata_nxt;
      latch_q <= latch_nxt;
    end
  end

  assign sdata_o = sdata_q;
  assign latch_o = latch_q;

  AST_STROBE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> (cyc_q == CW'(STROBE_CYC))); // R7

  AST_NO_STROBE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_d == FMT_START) |-> !latch_q); // R8

endmodule

// File: rtl/led_serial_out.sv
module led_serial_out
  import led_serial_pkg::*;
#(
  parameter int unsigned CLK_DIV    = SCLK_RATIO,
  parameter int unsigned LED_W      = LED_COUNT,
  parameter int unsigned FRAME      = FRAME_CYCLES,
  parameter int unsigned DATA_FIRST = START_DATA_FIRST,
  parameter int unsigned STROBE_CYC = STROBE_CYCLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             mode_sel,
  input  logic [LED_W-1:0] led_vec,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             ser_latch
);

  localparam int unsigned CW = $clog2(FRAME + 1);

  logic             rst_sync_n;
  logic             fall_en;
  logic             prerise_en;
  logic [CW-1:0]    cyc_d;
  logic [CW-1:0]    cyc_q;
  frame_fmt_e       fmt_d;
  frame_fmt_e       fmt_in;
  logic [LED_W-1:0] led_d;

  assign fmt_in = frame_fmt_e'(mode_sel);

  lso_reset_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  lso_sclk_div #(.RATIO(CLK_DIV)) u_div (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tick_en      (tick_en),
    .sclk_o       (ser_clk),
    .fall_en_o    (fall_en),
    .prerise_en_o (prerise_en)
  );

  lso_frame_seq #(.FRAME(FRAME), .LED_W(LED_W), .CW(CW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fall_en (fall_en),
    .fmt_i   (fmt_in),
    .led_i   (led_vec),
    .cyc_d_o (cyc_d),
    .fmt_d_o (fmt_d),
    .led_d_o (led_d),
    .cyc_q_o (cyc_q)
  );

  lso_bit_drive #(
    .FRAME(FRAME), .LED_W(LED_W), .DATA_FIRST(DATA_FIRST),
    .STROBE_CYC(STROBE_CYC), .CW(CW)
  ) u_drv (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fall_en    (fall_en),
    .prerise_en (prerise_en),
    .cyc_d      (cyc_d),
    .fmt_d      (fmt_d),
    .led_d      (led_d),
    .cyc_q      (cyc_q),
    .sdata_o    (ser_data),
    .latch_o    (ser_latch)
  );

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$fell(ser_clk) |-> $stable(ser_data)); // R2

  AST_STROBE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ser_latch |-> !ser_clk); // R7

endmodule

// File: tb/led_serial_out_test.sv
`timescale 1ns/1ps
module led_serial_out_test;

  localparam int FRAME = 36;
  localparam int DIV   = 4;
  localparam logic [12:0] VECS [0:7] = '{
    13'h0FFF, 13'h1FFF, 13'h0001, 13'h1001,
    13'h0800, 13'h1800, 13'h0A5C, 13'h135A
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        mode_sel;
  logic [11:0] led_vec;
  logic        ser_clk, ser_data, ser_latch;

  int n_checks = 0;
  int n_fail   = 0;
  int clk_cnt  = 0;

  int rise_cnt = 0;
  int cur_cyc  = 0;
  int frames   = 0;
  logic [FRAME-1:0] frame_bits = '0;
  logic [FRAME-1:0] done_bits  = '0;
  int lat_rises = 0, lat_at_start = 0, lat_cyc = 0, lat_time = 0, lat_gap = 0;
  int done_lat = 0, done_lcyc = 0;
  int bad_r2 = 0, bad_r7 = 0;
  logic gate = 1'b0;
  int   tick_cnt = 0;

  always #2.5 clk = ~clk;

  led_serial_out uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
    .led_vec(led_vec), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FRAME-1:0] exp_frame(input logic m, input logic [11:0] l);
    logic [FRAME-1:0] b = '0;
    if (!m) begin
      b[0] = 1'b1;
      for (int i = 0; i < 12; i++) b[3 + i] = l[i];
    end else begin
      for (int i = 0; i < 12; i++) b[i] = l[i];
    end
    return b;
  endfunction

  always @(posedge clk) begin
    clk_cnt++;
    if (clk_cnt > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", clk_cnt, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (gate) begin
      tick_en  <= (tick_cnt == 0);
      tick_cnt <= (tick_cnt == 2) ? 0 : tick_cnt + 1;
    end else begin
      tick_en  <= 1'b1;
      tick_cnt <= 0;
    end
  end

  // frame monitor: one bit per serial clock rise
  always @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt = 0;
      cur_cyc  = 0;
    end else begin
      rise_cnt = rise_cnt + 1;
      if (rise_cnt == 1) begin
        chk(ser_data == 1'b0, "R10 lead-in rise data", ser_data, 0);
      end else begin
        cur_cyc = ((rise_cnt - 2) % FRAME) + 1;
        if (cur_cyc == 1) lat_at_start = lat_rises;
        frame_bits[cur_cyc - 1] = ser_data;
        if (cur_cyc == FRAME) begin
          done_bits = frame_bits;
          done_lat  = lat_rises - lat_at_start;
          done_lcyc = lat_cyc;
          frames    = frames + 1;
        end
      end
    end
  end

  logic prev_d = 1'b0, prev_c = 1'b0, prev_l = 1'b0, prev_r = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_r && (ser_data != prev_d) && !(prev_c && !ser_clk)) bad_r2++;
    if (ser_latch && ser_clk) bad_r7++;
    if (ser_latch && !prev_l) begin
      lat_rises++;
      lat_cyc  = cur_cyc + 1;
      lat_gap  = clk_cnt - lat_time;
      lat_time = clk_cnt;
    end
    prev_d = ser_data;
    prev_c = ser_clk;
    prev_l = ser_latch;
    prev_r = rst_n;
  end

  task automatic check_done(input logic m, input logic [11:0] l, input string tag);
    logic [FRAME-1:0] e = exp_frame(m, l);
    chk(done_bits == e, m ? {tag, " R5 R6 format1 bits"} : {tag, " R4 R6 format0 bits"},
        int'(done_bits), int'(e));
    if (m) chk((done_lat == 1) && (done_lcyc == 35), {tag, " R7 strobe once in cycle 35"},
               done_lat * 100 + done_lcyc, 135);
    else   chk(done_lat == 0, {tag, " R8 no strobe in format0"}, done_lat, 0);
  endtask

  task automatic run_frame(input logic m, input logic [11:0] l, input string tag);
    int f;
    f = frames;
    wait (frames == f + 1);
    @(negedge clk);
    mode_sel = m;
    led_vec  = l;
    f = frames;
    wait (frames == f + 1);
    check_done(m, l, tag);
  endtask

  task automatic measure(input int exp_half, input string tag);
    int nh, nl;
    @(posedge ser_clk);
    nh = 0;
    @(negedge clk);
    while (ser_clk) begin nh++; @(negedge clk); end
    nl = 0;
    while (!ser_clk) begin nl++; @(negedge clk); end
    chk((nh == exp_half) && (nl == exp_half), tag, nh * 100 + nl, exp_half * 101);
  endtask

  initial begin
    int f;
    rst_n = 1'b0; mode_sel = 1'b0; led_vec = 12'h000; tick_en = 1'b1;
    repeat (5) @(negedge clk);
    chk({ser_clk, ser_data, ser_latch} == 3'b000, "R10 outputs low in reset",
        {ser_clk, ser_data, ser_latch}, 0);
    rst_n = 1'b1;

    measure(DIV / 2, "R3 half periods");

    for (int v = 0; v < 8; v++) begin
      run_frame(VECS[v][12], VECS[v][11:0], $sformatf("vec%0d", v));
    end

    // R1: strobe spacing over consecutive format-1 frames
    run_frame(1'b1, 12'h6A5, "R1 pre");
    f = frames;
    wait (frames == f + 1);
    chk(lat_gap == FRAME * DIV, "R1 frame length in ticks", lat_gap, FRAME * DIV);
    check_done(1'b1, 12'h6A5, "R1 repeat");

    // R9: inputs changed in the middle of a frame
    f = frames;
    wait (frames == f + 1);
    @(negedge clk);
    mode_sel = 1'b0; led_vec = 12'h3C1;
    f = frames;
    wait ((cur_cyc == 10) && (frames == f));
    @(negedge clk);
    mode_sel = 1'b1; led_vec = 12'hC3E;
    wait (frames == f + 1);
    check_done(1'b0, 12'h3C1, "R9 old snapshot kept");
    wait (frames == f + 2);
    check_done(1'b1, 12'hC3E, "R9 new snapshot next frame");

    // R11: thinned tick
    gate = 1'b1;
    measure(3 * DIV / 2, "R11 phases follow tick");
    run_frame(1'b1, 12'h0F0, "R11 gated");
    gate = 1'b0;

    // R10: reset in the middle of a frame
    f = frames;
    wait ((cur_cyc == 20) && (frames == f));
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = 1'b1; led_vec = 12'h3C3;
    repeat (3) @(negedge clk);
    chk({ser_clk, ser_data, ser_latch} == 3'b000, "R10 outputs low in second reset",
        {ser_clk, ser_data, ser_latch}, 0);
    rst_n = 1'b1;
    f = frames;
    wait (frames == f + 1);
    check_done(1'b1, 12'h3C3, "R10 first frame after reset");

    chk(bad_r2 == 0, "R2 data moved off falling edge", bad_r2, 0);
    chk(bad_r7 == 0, "R7 strobe high with clock high", bad_r7, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule